// File: doc/BRIEF.md
# Receive Startup and Framing Sequencer

This block runs one receive operation from its start strobe until the incoming signal goes away. A start in the idle phase loads a programmable wait count, raised to a floor of three. The count drops by one on every bit-clock enable. During the last three counts an analog-prepare output is driven. When the count runs out, the block watches a sampled signal level and compares it against a 4-bit minimum level.

Once the level rises strictly above the minimum, the block looks for a start-of-frame marker. The marker is a single 1 on the demodulated bit input. After the marker, the block packs the following bits into bytes, least significant bit first, and writes each finished byte to a FIFO as a one-cycle write strobe with data. If the level falls to the minimum or below while searching for the marker or receiving data, reception ends. Any partial byte is dropped and a sticky receive interrupt flag is raised. A 3-bit code reports the current phase throughout.

Top module: `rx_frame_seq`

## Requirements
- R1: After reset, stateCode is 0, prepEn is 0, fifoWr is 0 and rxIrq is 0.
- R2: In the idle phase, startIn loads the wait count and decrements it by one only on clock edges where bitEn is high. stateCode is 1 while the count is above 3.
- R3: While the count is 3, 2 or 1, prepEn is 1 and stateCode is 2. The bitEn edge that takes the count from 1 to 0 enters the monitor phase: stateCode becomes 3 and prepEn becomes 0.
- R4: A wait value below 3 is treated as 3. The block enters the prepare phase at once and stays there for exactly three bitEn edges.
- R5: In the monitor phase, on a bitEn edge, the block moves to start-of-frame search (stateCode 4) only when levelIn > minLevel. A level equal to or below minLevel keeps it in the monitor phase.
- R6: In start-of-frame search, 0 bits are ignored. A 1 bit with the level above minLevel enters the data phase (stateCode 5). Neither case writes the FIFO.
- R7: In the data phase, bits taken on bitEn edges fill a byte LSB first. The edge that takes the eighth bit makes fifoWr high for exactly one cycle, with the byte on fifoData.
- R8: On a bitEn edge in start-of-frame search or the data phase with levelIn <= minLevel, the block returns to idle (stateCode 0) and sets rxIrq. Any partial byte is discarded without a FIFO write.
- R9: rxIrq stays set until irqClr is sampled high. If termination and irqClr happen on the same edge, rxIrq is set.
- R10: startIn has no effect outside the idle phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Start strobe, honoured only when idle |
| waitVal | input | WAIT_W | Wait count loaded at start |
| minLevel | input | LVL_W | Signal-level threshold |
| levelIn | input | LVL_W | Sampled signal level |
| bitIn | input | 1 | Demodulated bit |
| bitEn | input | 1 | Bit-clock enable |
| irqClr | input | 1 | Clears the receive interrupt flag |
| fifoWr | output | 1 | One-cycle FIFO write strobe |
| fifoData | output | BYTE_W | Assembled byte |
| prepEn | output | 1 | Analog-prepare enable |
| rxIrq | output | 1 | Sticky receive-done interrupt flag |
| stateCode | output | 3 | Phase: 0 idle, 1 wait, 2 prepare, 3 monitor, 4 SOF search, 5 data |

## Verification
The bench builds the block with its defaults: an 8-bit wait count, a 4-bit level and 8-bit bytes. With these values, clamped wait values (below 3), a level exactly equal to the threshold, and both bit-polarity extremes of a byte all fall within short runs. Bit-enable gaps inside a byte and a start pulse during the countdown are also covered. These check that only bitEn edges advance the sequence.

// File: rtl/rx_seq_pkg.sv
package rx_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_COUNT = 3'd1,
    ST_MON   = 3'd3,
    ST_SOF   = 3'd4,
    ST_DATA  = 3'd5
  } seqState_t;

  localparam logic [2:0] CODE_IDLE = 3'd0;
  localparam logic [2:0] CODE_WAIT = 3'd1;
  localparam logic [2:0] CODE_PREP = 3'd2;
  localparam logic [2:0] CODE_MON  = 3'd3;
  localparam logic [2:0] CODE_SOF  = 3'd4;
  localparam logic [2:0] CODE_DATA = 3'd5;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic clrBits;
    logic shiftBit;
  } dpCmd_t;
endpackage

// File: rtl/rx_seq_dpath.sv
module rx_seq_dpath
  import rx_seq_pkg::*;
#(
  parameter int WAIT_W   = 8,
  parameter int LVL_W    = 4,
  parameter int BYTE_W   = 8,
  parameter int MIN_WAIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [WAIT_W-1:0] waitVal,
  input  logic [LVL_W-1:0]  levelIn,
  input  logic [LVL_W-1:0]  minLevel,
  input  logic              bitIn,
  output logic              cntLast,
  output logic              cntAboveWin,
  output logic              levelOk,
  output logic              fifoWr,
  output logic [BYTE_W-1:0] fifoData
);
  localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [WAIT_W-1:0] FLOOR = WAIT_W'(MIN_WAIT);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(BYTE_W - 1);

  logic [WAIT_W-1:0] cnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] shiftNext;
  logic              byteFull;

  assign cntLast     = (cnt == WAIT_W'(1));
  assign cntAboveWin = (cnt > FLOOR);
  assign levelOk     = (levelIn > minLevel);
  assign byteFull    = (bitCnt == LAST_BIT);
  assign shiftNext   = {bitIn, shiftReg[BYTE_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.loadCnt) begin
      cnt <= (waitVal < FLOOR) ? FLOOR : waitVal;
    end else if (cmd.decCnt) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      fifoWr   <= 1'b0;
      fifoData <= '0;
    end else begin
      fifoWr <= 1'b0;
      if (cmd.clrBits) begin
        bitCnt <= '0;
      end else if (cmd.shiftBit) begin
        shiftReg <= shiftNext;
        if (byteFull) begin
          bitCnt   <= '0;
          fifoWr   <= 1'b1;
          fifoData <= shiftNext;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R4
  load_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadCnt |=> cnt >= FLOOR);

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.decCnt && !cmd.loadCnt) |=> cnt == $past(cnt) - 1'b1);

  // R7
  one_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWr |=> !fifoWr);
endmodule

// File: rtl/rx_seq_ctrl.sv
module rx_seq_ctrl
  import rx_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       bitEn,
  input  logic       bitIn,
  input  logic       irqClr,
  input  logic       cntLast,
  input  logic       cntAboveWin,
  input  logic       levelOk,
  output dpCmd_t     cmd,
  output logic       prepEn,
  output logic       rxIrq,
  output logic [2:0] stateCode
);
  seqState_t st, nxt;
  logic      finish;

  always_comb begin
    cmd    = '0;
    nxt    = st;
    finish = 1'b0;
    case (st)
      ST_IDLE: begin
        if (startIn) begin
          cmd.loadCnt = 1'b1;
          nxt         = ST_COUNT;
        end
      end
      ST_COUNT: begin
        if (bitEn) begin
          cmd.decCnt = 1'b1;
          if (cntLast) nxt = ST_MON;
        end
      end
      ST_MON: begin
        if (bitEn && levelOk) nxt = ST_SOF;
      end
      ST_SOF: begin
        if (bitEn) begin
          if (!levelOk) begin
            finish = 1'b1;
          end else if (bitIn) begin
            cmd.clrBits = 1'b1;
            nxt         = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (bitEn) begin
          if (!levelOk) finish = 1'b1;
          else          cmd.shiftBit = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (finish) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= ST_IDLE;
      rxIrq <= 1'b0;
    end else begin
      st <= nxt;
      if (finish)      rxIrq <= 1'b1;
      else if (irqClr) rxIrq <= 1'b0;
    end
  end

  assign prepEn = (st == ST_COUNT) && !cntAboveWin;

  always_comb begin
    case (st)
      ST_COUNT: stateCode = cntAboveWin ? CODE_WAIT : CODE_PREP;
      ST_MON:   stateCode = CODE_MON;
      ST_SOF:   stateCode = CODE_SOF;
      ST_DATA:  stateCode = CODE_DATA;
      default:  stateCode = CODE_IDLE;
    endcase
  end

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((st == ST_SOF || st == ST_DATA) && bitEn && !levelOk) |=> (rxIrq && st == ST_IDLE));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxIrq && !irqClr) |=> rxIrq);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_IDLE && startIn && !bitEn) |=> st == $past(st));

  // R3
  prep_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    prepEn |-> stateCode == CODE_PREP);
endmodule

// File: rtl/rx_frame_seq.sv
module rx_frame_seq
  import rx_seq_pkg::*;
#(
  parameter int WAIT_W   = 8,
  parameter int LVL_W    = 4,
  parameter int BYTE_W   = 8,
  parameter int MIN_WAIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [WAIT_W-1:0] waitVal,
  input  logic [LVL_W-1:0]  minLevel,
  input  logic [LVL_W-1:0]  levelIn,
  input  logic              bitIn,
  input  logic              bitEn,
  input  logic              irqClr,
  output logic              fifoWr,
  output logic [BYTE_W-1:0] fifoData,
  output logic              prepEn,
  output logic              rxIrq,
  output logic [2:0]        stateCode
);
  dpCmd_t cmd;
  logic   cntLast, cntAboveWin, levelOk;

  rx_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .bitEn(bitEn), .bitIn(bitIn),
    .irqClr(irqClr), .cntLast(cntLast), .cntAboveWin(cntAboveWin),
    .levelOk(levelOk), .cmd(cmd), .prepEn(prepEn), .rxIrq(rxIrq),
    .stateCode(stateCode)
  );

  rx_seq_dpath #(
    .WAIT_W(WAIT_W), .LVL_W(LVL_W), .BYTE_W(BYTE_W), .MIN_WAIT(MIN_WAIT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .waitVal(waitVal), .levelIn(levelIn),
    .minLevel(minLevel), .bitIn(bitIn), .cntLast(cntLast),
    .cntAboveWin(cntAboveWin), .levelOk(levelOk), .fifoWr(fifoWr),
    .fifoData(fifoData)
  );
endmodule

// File: tb/rx_frame_seq_bench.sv
module rx_frame_seq_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0;
  logic [7:0] waitVal = '0;
  logic [3:0] minLevel = 4'd5;
  logic [3:0] levelIn = '0;
  logic       bitIn = 1'b0;
  logic       bitEn = 1'b0;
  logic       irqClr = 1'b0;
  logic       fifoWr;
  logic [7:0] fifoData;
  logic       prepEn;
  logic       rxIrq;
  logic [2:0] stateCode;

  int checks = 0;
  int fails = 0;
  int expQ[$];
  bit done = 0;

  always #5 clk = ~clk;

  rx_frame_seq u_rx_frame_seq (
    .clk(clk), .rstN(rstN), .startIn(startIn), .waitVal(waitVal),
    .minLevel(minLevel), .levelIn(levelIn), .bitIn(bitIn), .bitEn(bitEn),
    .irqClr(irqClr), .fifoWr(fifoWr), .fifoData(fifoData), .prepEn(prepEn),
    .rxIrq(rxIrq), .stateCode(stateCode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit en, input bit b, input logic [3:0] lvl);
    bitEn = en; bitIn = b; levelIn = lvl;
    @(posedge clk); #2;
    bitEn = 1'b0; startIn = 1'b0; irqClr = 1'b0;
  endtask

  // driver: push expected byte, then feed its bits LSB first
  task automatic sendByte(input logic [7:0] v, input bit gaps);
    expQ.push_back(int'(v));
    for (int i = 0; i < 8; i++) begin
      step(1'b1, v[i], 4'd9);
      if (gaps) step(1'b0, ~v[i], 4'd9);
    end
  endtask

  // monitor: pop and compare every FIFO write (R7, R8)
  initial begin
    forever begin
      @(posedge clk); #3;
      if (fifoWr) begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R8: actual unexpected write %0d expected no write", fifoData);
        end else begin
          int e;
          e = expQ.pop_front();
          if (int'(fifoData) != e) begin
            fails++;
            $display("FAIL R7: actual %0d expected %0d", fifoData, e);
          end
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 state", stateCode, 0);
    chk("R1 prep", prepEn, 0);
    chk("R1 wr", fifoWr, 0);
    chk("R1 irq", rxIrq, 0);
    rstN = 1'b1;
    step(1'b0, 1'b0, 4'd0);

    // countdown from 5
    startIn = 1'b1; waitVal = 8'd5;
    step(1'b0, 1'b0, 4'd0);
    chk("R2 wait code", stateCode, 1);
    step(1'b1, 1'b0, 4'd0);
    chk("R2 count 4", stateCode, 1);
    startIn = 1'b1; waitVal = 8'd50;
    step(1'b0, 1'b0, 4'd0);
    chk("R10 start ignored", stateCode, 1);
    step(1'b0, 1'b0, 4'd0);
    chk("R2 no bitEn hold", stateCode, 1);
    step(1'b1, 1'b0, 4'd0);
    chk("R3 prep code at 3", stateCode, 2);
    chk("R3 prepEn at 3", prepEn, 1);
    step(1'b1, 1'b0, 4'd0);
    step(1'b1, 1'b0, 4'd0);
    chk("R3 prepEn at 1", prepEn, 1);
    step(1'b1, 1'b0, 4'd0);
    chk("R3 monitor code", stateCode, 3);
    chk("R3 prepEn off", prepEn, 0);

    // threshold
    step(1'b1, 1'b1, 4'd5);
    chk("R5 equal level stays", stateCode, 3);
    step(1'b1, 1'b0, 4'd6);
    chk("R5 above level", stateCode, 4);
    step(1'b1, 1'b0, 4'd9);
    step(1'b1, 1'b0, 4'd9);
    chk("R6 zero bits ignored", stateCode, 4);
    step(1'b1, 1'b1, 4'd9);
    chk("R6 sof to data", stateCode, 5);
    chk("R6 no write", fifoWr, 0);

    sendByte(8'hA5, 1'b0);
    sendByte(8'h3C, 1'b0);
    sendByte(8'hFF, 1'b0);
    sendByte(8'h00, 1'b0);
    chk("R7 still data", stateCode, 5);
    step(1'b1, 1'b1, 4'd9);
    step(1'b1, 1'b0, 4'd9);
    step(1'b1, 1'b1, 4'd9);
    step(1'b1, 1'b1, 4'd4);
    chk("R8 idle", stateCode, 0);
    chk("R8 irq", rxIrq, 1);
    chk("R8 partial dropped", fifoWr, 0);
    repeat (4) step(1'b0, 1'b0, 4'd0);
    chk("R9 irq held", rxIrq, 1);
    irqClr = 1'b1;
    step(1'b0, 1'b0, 4'd0);
    chk("R9 irq cleared", rxIrq, 0);

    // clamped wait value
    startIn = 1'b1; waitVal = 8'd1;
    step(1'b0, 1'b0, 4'd0);
    chk("R4 clamp prep code", stateCode, 2);
    chk("R4 clamp prepEn", prepEn, 1);
    step(1'b1, 1'b0, 4'd0);
    step(1'b1, 1'b0, 4'd0);
    chk("R4 still prep", stateCode, 2);
    step(1'b1, 1'b0, 4'd0);
    chk("R4 monitor after three", stateCode, 3);
    step(1'b1, 1'b0, 4'd2);
    chk("R5 low level stays", stateCode, 3);
    chk("R5 no irq in monitor", rxIrq, 0);
    step(1'b1, 1'b0, 4'd9);
    irqClr = 1'b1;
    step(1'b1, 1'b0, 4'd5);
    chk("R8 loss in sof", stateCode, 0);
    chk("R9 set beats clear", rxIrq, 1);
    irqClr = 1'b1;
    step(1'b0, 1'b0, 4'd0);

    // gaps between bits, wait value 0
    startIn = 1'b1; waitVal = 8'd0;
    step(1'b0, 1'b0, 4'd0);
    repeat (3) step(1'b1, 1'b0, 4'd0);
    step(1'b1, 1'b0, 4'd9);
    step(1'b1, 1'b1, 4'd9);
    chk("R6 data again", stateCode, 5);
    sendByte(8'h81, 1'b1);
    step(1'b1, 1'b0, 4'd0);
    chk("R8 final idle", stateCode, 0);
    repeat (3) step(1'b0, 1'b0, 4'd0);
    chk("R7 all bytes written", expQ.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule